// File: doc/BRIEF.md
# Loop Exit Branch Predictor

This block sits beside a general direction predictor and removes the miss that an always-taken guess suffers on the last pass of a counted loop. It watches resolved conditional branches, notices those that are taken several times in a row and then fall through, and gives each such branch a table entry that holds its learned trip count, the number of taken passes seen in the current loop instance, and a two-bit confidence. Once the same trip count has been seen often enough, the block's prediction is flagged confident and the front end may let it override the base predictor.

The table is direct-mapped and tagged. A lookup is purely combinational on the lookup PC and reflects every resolve accepted at an earlier clock edge. A resolve trains the entry on a tag hit; on a miss it feeds a single candidate tracker that counts consecutive taken outcomes of one PC, and a not-taken outcome closing a long enough run allocates an entry. The trip count is defined as the number of executions of the branch per loop instance, the exit included, so a loop taken four times and then not taken has a trip count of 5.

Top module: `loop_exit_pred`

## Requirements
- R1: While reset is asserted and after its release, before any resolve, every lookup reports lk_hit=0, lk_conf=0 and lk_taken=1.
- R2: A PC maps to entry index PC[5:2] and tag PC[13:6] (default widths); a lookup hits only when that entry is valid and its tag matches, so a PC differing only in bits 13:6 misses.
- R3: A resolve that misses with a taken outcome never creates an entry, however many times it repeats.
- R4: A not-taken resolve that misses allocates an entry only when the same PC was resolved taken at least ALLOC_MIN (2) times in a row just before; the entry gets trip count = run + 1, confidence 0, current count 0.
- R5: A taken miss of a different PC restarts the run count, and any not-taken miss ends the run.
- R6: On a hit, lk_taken is 0 exactly when current count + 1 equals the learned trip count, and 1 otherwise.
- R7: A not-taken resolve on a hit whose observed trip count (current count + 1) equals the learned one raises confidence by one, saturating at 3; lk_conf is 1 only on a hit at confidence 3.
- R8: A not-taken resolve on a hit whose observed trip count differs replaces the learned trip count and clears confidence.
- R9: A not-taken resolve on a hit resets the current count to 0; a taken resolve on a hit adds one to it.
- R10: Lookups never change state; a resolve takes effect on the lookup from the clock edge that accepts it onward, and no edge without up_valid changes any entry.
- R11: An allocation at an index held by another tag replaces that entry, which then misses.
- R12: The current count and the candidate run saturate at 255 (CNT_W=8); a loop of more than 255 taken passes is learned with trip count 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| lk_pc | input | PC_W | PC of the branch being predicted |
| lk_hit | output | 1 | Lookup PC is tracked by the table |
| lk_taken | output | 1 | Predicted direction (1 when not tracked) |
| lk_conf | output | 1 | Prediction is confident enough to override the base predictor |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The checker watches, on every cycle, the write decision taken for each resolve: that idle cycles and taken misses never write, that an exit on a hit always clears the current count, that a trip mismatch clears confidence and stores the observed count, that a match steps confidence, that counts saturate, and that a confident lookup is always a hit. Whether the table actually learns a loop, predicts its exit on the right pass, recovers from a changed trip count, handles interleaved candidates and index aliases can only be shown by the bench's sequences of resolves followed by lookups, which compare against an independent model of the requirements.

// File: rtl/lep_pkg.sv
package lep_pkg;
  localparam int CONF_W = 2;
  typedef logic [CONF_W-1:0] conf_t;
  localparam conf_t CONF_FULL = conf_t'(2'b11);

  function automatic conf_t conf_step(input conf_t c);
    return (c == CONF_FULL) ? c : c + conf_t'(1);
  endfunction
endpackage

// File: rtl/lep_rst_sync.sv
module lep_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_q = s1_q;
endmodule

// File: rtl/lep_hash.sv
module lep_hash #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_LO + IDX_W;
  localparam int TAG_HI = TAG_LO + TAG_W - 1;

  assign idx = pc[TAG_LO-1:IDX_LO];
  assign tag = pc[TAG_HI:TAG_LO];

  logic unused_pc_bits;
  generate
    if (TAG_HI < PC_W - 1) begin : g_hi
      assign unused_pc_bits = ^{pc[PC_W-1:TAG_HI+1], pc[IDX_LO-1:0]};
    end else begin : g_nohi
      assign unused_pc_bits = ^pc[IDX_LO-1:0];
    end
  endgenerate
endmodule

// File: rtl/lep_table.sv
module lep_table
  import lep_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int CNT_W  = 8,
  parameter int TRIP_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  // read port A (lookup)
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_valid,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [TRIP_W-1:0] ra_trip,
  output logic [CNT_W-1:0]  ra_cur,
  output conf_t             ra_conf,
  // read port B (training)
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_valid,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [TRIP_W-1:0] rb_trip,
  output logic [CNT_W-1:0]  rb_cur,
  output conf_t             rb_conf,
  // write port
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [TRIP_W-1:0] wr_trip,
  input  logic [CNT_W-1:0]  wr_cur,
  input  conf_t             wr_conf
);
  localparam int ENTRIES = 1 << IDX_W;

  logic              v_arr    [ENTRIES];
  logic [TAG_W-1:0]  tag_arr  [ENTRIES];
  logic [TRIP_W-1:0] trip_arr [ENTRIES];
  logic [CNT_W-1:0]  cur_arr  [ENTRIES];
  conf_t             conf_arr [ENTRIES];

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic              sel;
      logic              v_q;
      logic [TAG_W-1:0]  tag_q;
      logic [TRIP_W-1:0] trip_q;
      logic [CNT_W-1:0]  cur_q;
      conf_t             conf_q;

      assign sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
        end else if (sel) begin
          v_q <= 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (sel) begin
          tag_q  <= wr_tag;
          trip_q <= wr_trip;
          cur_q  <= wr_cur;
          conf_q <= wr_conf;
        end
      end

      assign v_arr[g]    = v_q;
      assign tag_arr[g]  = tag_q;
      assign trip_arr[g] = trip_q;
      assign cur_arr[g]  = cur_q;
      assign conf_arr[g] = conf_q;
    end
  endgenerate

  assign ra_valid = v_arr[ra_idx];
  assign ra_tag   = tag_arr[ra_idx];
  assign ra_trip  = trip_arr[ra_idx];
  assign ra_cur   = cur_arr[ra_idx];
  assign ra_conf  = conf_arr[ra_idx];

  assign rb_valid = v_arr[rb_idx];
  assign rb_tag   = tag_arr[rb_idx];
  assign rb_trip  = trip_arr[rb_idx];
  assign rb_cur   = cur_arr[rb_idx];
  assign rb_conf  = conf_arr[rb_idx];
endmodule

// File: rtl/lep_train.sv
module lep_train
  import lep_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int TAG_W     = 8,
  parameter int CNT_W     = 8,
  parameter int TRIP_W    = CNT_W + 1,
  parameter int ALLOC_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic              up_taken,
  input  logic              hit,
  input  logic [TAG_W-1:0]  up_tag,
  input  logic [TRIP_W-1:0] e_trip,
  input  logic [CNT_W-1:0]  e_cur,
  input  conf_t             e_conf,
  output logic              wr_en,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [TRIP_W-1:0] wr_trip,
  output logic [CNT_W-1:0]  wr_cur,
  output conf_t             wr_conf
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] RUN_NEED = CNT_W'(ALLOC_MIN);

  // candidate tracker state
  logic             cand_v_q, cand_v_n;
  logic [PC_W-1:0]  cand_pc_q, cand_pc_n;
  logic [CNT_W-1:0] cand_run_q, cand_run_n;

  logic [TRIP_W-1:0] observed;
  logic              same_cand;

  assign observed  = TRIP_W'(e_cur) + TRIP_W'(1);
  assign same_cand = cand_v_q && (cand_pc_q == up_pc);

  always_comb begin
    wr_en      = 1'b0;
    wr_tag     = up_tag;
    wr_trip    = e_trip;
    wr_cur     = e_cur;
    wr_conf    = e_conf;
    cand_v_n   = cand_v_q;
    cand_pc_n  = cand_pc_q;
    cand_run_n = cand_run_q;

    if (up_valid) begin
      if (hit) begin
        wr_en = 1'b1;
        if (up_taken) begin
          wr_cur = (e_cur == CNT_MAX) ? e_cur : e_cur + CNT_W'(1);
        end else begin
          wr_cur = '0;
          if (observed == e_trip) begin
            wr_conf = conf_step(e_conf);
          end else begin
            wr_trip = observed;
            wr_conf = '0;
          end
        end
      end else if (up_taken) begin
        if (same_cand) begin
          cand_run_n = (cand_run_q == CNT_MAX) ? cand_run_q : cand_run_q + CNT_W'(1);
        end else begin
          cand_v_n   = 1'b1;
          cand_pc_n  = up_pc;
          cand_run_n = CNT_W'(1);
        end
      end else begin
        cand_v_n = 1'b0;
        if (same_cand && (cand_run_q >= RUN_NEED)) begin
          wr_en   = 1'b1;
          wr_trip = TRIP_W'(cand_run_q) + TRIP_W'(1);
          wr_cur  = '0;
          wr_conf = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_v_q <= 1'b0;
    end else begin
      cand_v_q <= cand_v_n;
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid) begin
      cand_pc_q  <= cand_pc_n;
      cand_run_q <= cand_run_n;
    end
  end
endmodule

// File: rtl/loop_exit_pred.sv
module loop_exit_pred
  import lep_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 4,
  parameter int TAG_W     = 8,
  parameter int CNT_W     = 8,
  parameter int ALLOC_MIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic            lk_conf,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int TRIP_W = CNT_W + 1;

  logic rst_q;

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;

  logic              la_valid, ub_valid;
  logic [TAG_W-1:0]  la_tag, ub_tag;
  logic [TRIP_W-1:0] la_trip, ub_trip;
  logic [CNT_W-1:0]  la_cur, ub_cur;
  conf_t             la_conf, ub_conf;

  logic              up_hit;
  logic              wr_en;
  logic [TAG_W-1:0]  wr_tag;
  logic [TRIP_W-1:0] wr_trip;
  logic [CNT_W-1:0]  wr_cur;
  conf_t             wr_conf;

  lep_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  lep_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash_lk (
    .pc  (lk_pc),
    .idx (lk_idx),
    .tag (lk_tag)
  );

  lep_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash_up (
    .pc  (up_pc),
    .idx (up_idx),
    .tag (up_tag)
  );

  lep_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W), .TRIP_W(TRIP_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_q),
    .ra_idx   (lk_idx),
    .ra_valid (la_valid),
    .ra_tag   (la_tag),
    .ra_trip  (la_trip),
    .ra_cur   (la_cur),
    .ra_conf  (la_conf),
    .rb_idx   (up_idx),
    .rb_valid (ub_valid),
    .rb_tag   (ub_tag),
    .rb_trip  (ub_trip),
    .rb_cur   (ub_cur),
    .rb_conf  (ub_conf),
    .wr_en    (wr_en),
    .wr_idx   (up_idx),
    .wr_tag   (wr_tag),
    .wr_trip  (wr_trip),
    .wr_cur   (wr_cur),
    .wr_conf  (wr_conf)
  );

  assign up_hit = ub_valid && (ub_tag == up_tag);

  lep_train #(
    .PC_W(PC_W), .TAG_W(TAG_W), .CNT_W(CNT_W), .TRIP_W(TRIP_W), .ALLOC_MIN(ALLOC_MIN)
  ) u_train (
    .clk      (clk),
    .rst_n    (rst_q),
    .up_valid (up_valid),
    .up_pc    (up_pc),
    .up_taken (up_taken),
    .hit      (up_hit),
    .up_tag   (up_tag),
    .e_trip   (ub_trip),
    .e_cur    (ub_cur),
    .e_conf   (ub_conf),
    .wr_en    (wr_en),
    .wr_tag   (wr_tag),
    .wr_trip  (wr_trip),
    .wr_cur   (wr_cur),
    .wr_conf  (wr_conf)
  );

  logic lk_match;
  assign lk_match = la_valid && (la_tag == lk_tag);
  assign lk_hit   = lk_match;
  assign lk_taken = !(lk_match && ((TRIP_W'(la_cur) + TRIP_W'(1)) == la_trip));
  assign lk_conf  = lk_match && (la_conf == CONF_FULL);
endmodule

// File: rtl/lep_chk.sv
module lep_chk
  import lep_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TRIP_W = CNT_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_taken,
  input logic              up_hit,
  input logic [TRIP_W-1:0] ub_trip,
  input logic [CNT_W-1:0]  ub_cur,
  input conf_t             ub_conf,
  input logic              wr_en,
  input logic [TRIP_W-1:0] wr_trip,
  input logic [CNT_W-1:0]  wr_cur,
  input conf_t             wr_conf,
  input logic              lk_hit,
  input logic              lk_conf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [TRIP_W-1:0] seen_trip;
  assign seen_trip = TRIP_W'(ub_cur) + TRIP_W'(1);

  // R7
  conf_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_conf |-> lk_hit);

  // R10
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |-> !wr_en);

  // R3
  taken_miss_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && !up_hit) |-> !wr_en);

  // R9
  exit_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && up_hit) |-> (wr_en && wr_cur == '0));

  // R8
  mismatch_relearn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && up_hit && seen_trip != ub_trip)
      |-> (wr_trip == seen_trip && wr_conf == '0));

  // R7
  match_conf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && up_hit && seen_trip == ub_trip && ub_conf != CONF_FULL)
      |-> (wr_conf == ub_conf + conf_t'(1) && wr_trip == ub_trip));

  // R12
  count_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && up_hit && ub_cur == CNT_MAX) |-> (wr_cur == CNT_MAX));
endmodule

bind loop_exit_pred lep_chk #(.CNT_W(CNT_W), .TRIP_W(CNT_W + 1)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .up_valid (up_valid),
  .up_taken (up_taken),
  .up_hit   (up_hit),
  .ub_trip  (ub_trip),
  .ub_cur   (ub_cur),
  .ub_conf  (ub_conf),
  .wr_en    (wr_en),
  .wr_trip  (wr_trip),
  .wr_cur   (wr_cur),
  .wr_conf  (wr_conf),
  .lk_hit   (lk_hit),
  .lk_conf  (lk_conf)
);

// File: tb/loop_exit_pred_test.sv
module loop_exit_pred_test;
  localparam int ENT = 16;
  localparam int CMAX = 255;

  logic        clk;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic        lk_hit, lk_taken, lk_conf;
  logic        up_valid;
  logic [31:0] up_pc;
  logic        up_taken;

  int checks = 0;
  int errors = 0;

  loop_exit_pred uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_conf(lk_conf), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // reference model, built from the requirements
  bit          m_v    [ENT];
  int          m_tag  [ENT];
  int          m_trip [ENT];
  int          m_cur  [ENT];
  int          m_conf [ENT];
  bit          c_v;
  logic [31:0] c_pc;
  int          c_run;

  function automatic int f_idx(input logic [31:0] pc); return int'(pc[5:2]); endfunction
  function automatic int f_tag(input logic [31:0] pc); return int'(pc[13:6]); endfunction
  function automatic bit f_hit(input logic [31:0] pc);
    return m_v[f_idx(pc)] && m_tag[f_idx(pc)] == f_tag(pc);
  endfunction
  function automatic bit f_taken(input logic [31:0] pc);
    if (!f_hit(pc)) return 1'b1;
    return !(m_cur[f_idx(pc)] + 1 == m_trip[f_idx(pc)]);
  endfunction
  function automatic bit f_conf(input logic [31:0] pc);
    return f_hit(pc) && m_conf[f_idx(pc)] == 3;
  endfunction

  function automatic void m_update(input logic [31:0] pc, input bit tk);
    int i;
    i = f_idx(pc);
    if (f_hit(pc)) begin
      if (tk) begin
        if (m_cur[i] < CMAX) m_cur[i]++;
      end else begin
        if (m_cur[i] + 1 == m_trip[i]) begin
          if (m_conf[i] < 3) m_conf[i]++;
        end else begin
          m_trip[i] = m_cur[i] + 1;
          m_conf[i] = 0;
        end
        m_cur[i] = 0;
      end
    end else if (tk) begin
      if (c_v && c_pc == pc) begin
        if (c_run < CMAX) c_run++;
      end else begin
        c_v = 1'b1; c_pc = pc; c_run = 1;
      end
    end else begin
      if (c_v && c_pc == pc && c_run >= 2) begin
        m_v[i] = 1'b1; m_tag[i] = f_tag(pc);
        m_trip[i] = c_run + 1; m_cur[i] = 0; m_conf[i] = 0;
      end
      c_v = 1'b0;
    end
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // compare the three lookup outputs for lk_pc with the model
  task automatic cmp_model(input string req);
    chk(req, "lk_hit",   int'(lk_hit),   int'(f_hit(lk_pc)));
    chk(req, "lk_taken", int'(lk_taken), int'(f_taken(lk_pc)));
    chk(req, "lk_conf",  int'(lk_conf),  int'(f_conf(lk_pc)));
  endtask

  // one cycle: drive at negedge, check lookup, let the edge take the resolve
  task automatic step(input logic [31:0] lpc, input bit uv, input logic [31:0] upc,
                      input bit ut, input string req);
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
    #1;
    cmp_model(req);
    @(posedge clk);
    if (uv) m_update(upc, ut);
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  // literal expectation at the current negedge, no resolve
  task automatic expect_lk(input logic [31:0] pc, input bit h, input bit tk, input bit cf,
                           input string req);
    lk_pc = pc; up_valid = 1'b0;
    #1;
    chk(req, "lk_hit",   int'(lk_hit),   int'(h));
    chk(req, "lk_taken", int'(lk_taken), int'(tk));
    chk(req, "lk_conf",  int'(lk_conf),  int'(cf));
  endtask

  // run one loop instance of the given trip count, looking up the loop PC itself
  task automatic loop_inst(input logic [31:0] pc, input int trip, input string req);
    for (int k = 0; k < trip - 1; k++) step(pc, 1'b1, pc, 1'b1, req);
    step(pc, 1'b1, pc, 1'b0, req);
  endtask

  localparam logic [31:0] PA = 32'h0000_1040;
  localparam logic [31:0] PB = 32'h0000_2008;
  localparam logic [31:0] PC_ = 32'h0000_300C;
  localparam logic [31:0] PD = 32'h0000_4010;
  localparam logic [31:0] PE = 32'h0000_5014;
  localparam logic [31:0] PF = 32'h0000_6018;
  localparam logic [31:0] PALIAS = PA + 32'h40;

  logic [31:0] rpc [6];
  int          rtrip [6];

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < ENT; i++) begin
      m_v[i] = 0; m_tag[i] = 0; m_trip[i] = 0; m_cur[i] = 0; m_conf[i] = 0;
    end
    c_v = 0; c_pc = '0; c_run = 0;
    rst_n = 1'b0; lk_pc = PA; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    expect_lk(PA, 0, 1, 0, "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 after release
    expect_lk(PB, 0, 1, 0, "R1");

    // R3: taken misses never allocate
    for (int k = 0; k < 6; k++) step(PB, 1'b1, PB, 1'b1, "R3");
    expect_lk(PB, 0, 1, 0, "R3");

    // R4: run of one then exit does not allocate; run of three does (trip 4)
    step(PC_, 1'b1, PC_, 1'b1, "R4");
    step(PC_, 1'b1, PC_, 1'b0, "R4");
    expect_lk(PC_, 0, 1, 0, "R4");
    loop_inst(PC_, 4, "R4");
    expect_lk(PC_, 1, 1, 0, "R4");

    // R5: interleaved taken miss restarts the run
    step(PD, 1'b1, PD, 1'b1, "R5");
    step(PD, 1'b1, PD, 1'b1, "R5");
    step(PD, 1'b1, PE, 1'b1, "R5");
    step(PD, 1'b1, PD, 1'b1, "R5");
    step(PD, 1'b1, PD, 1'b0, "R5");
    expect_lk(PD, 0, 1, 0, "R5");

    // R6/R7/R9: learn trip 5, build confidence, predict exit on the fifth pass
    loop_inst(PA, 5, "R4");
    for (int n = 0; n < 3; n++) loop_inst(PA, 5, "R7");
    expect_lk(PA, 1, 1, 1, "R7");
    for (int k = 0; k < 4; k++) begin
      expect_lk(PA, 1, 1, 1, "R6");
      step(PA, 1'b1, PA, 1'b1, "R9");
    end
    expect_lk(PA, 1, 0, 1, "R6");
    step(PA, 1'b1, PA, 1'b0, "R9");
    expect_lk(PA, 1, 1, 1, "R9");

    // R10: many lookup-only cycles change nothing
    for (int k = 0; k < 5; k++) step(PA, 1'b0, PA, 1'b0, "R10");
    expect_lk(PA, 1, 1, 1, "R10");

    // R8: shorter instance relearns trip 3 and clears confidence
    loop_inst(PA, 3, "R8");
    expect_lk(PA, 1, 1, 0, "R8");
    step(PA, 1'b1, PA, 1'b1, "R8");
    step(PA, 1'b1, PA, 1'b1, "R8");
    expect_lk(PA, 1, 0, 0, "R8");
    step(PA, 1'b1, PA, 1'b0, "R8");

    // R2/R11: same index, different tag misses, then replaces
    expect_lk(PALIAS, 0, 1, 0, "R2");
    loop_inst(PALIAS, 3, "R11");
    expect_lk(PALIAS, 1, 1, 0, "R11");
    expect_lk(PA, 0, 1, 0, "R11");

    // R12: very long loop saturates and learns trip 256
    loop_inst(PF, 301, "R12");
    expect_lk(PF, 1, 1, 0, "R12");
    for (int k = 0; k < 300; k++) step(PF, 1'b1, PF, 1'b1, "R12");
    expect_lk(PF, 1, 0, 0, "R12");
    step(PF, 1'b1, PF, 1'b0, "R12");

    // random loops, some sharing an index, with noise branches
    rpc[0] = 32'h0000_0100; rpc[1] = 32'h0000_0140; rpc[2] = 32'h0000_0A24;
    rpc[3] = 32'h0000_7A28; rpc[4] = 32'h0000_0B3C; rpc[5] = 32'h0000_0C3C;
    rtrip[0] = 3; rtrip[1] = 7; rtrip[2] = 2; rtrip[3] = 12; rtrip[4] = 5; rtrip[5] = 9;
    for (int r = 0; r < 400; r++) begin
      int li;
      int tr;
      li = int'($urandom % 6);
      tr = rtrip[li] + ((($urandom % 8) == 0) ? 1 : 0);
      for (int k = 0; k < tr; k++) begin
        logic [31:0] probe;
        probe = rpc[$urandom % 6];
        if (($urandom % 10) == 0)
          step(probe, 1'b1, 32'h0000_9000 + 32'($urandom % 4) * 4, 1'($urandom), "R6");
        if (($urandom % 6) == 0) step(probe, 1'b0, '0, 1'b0, "R10");
        step(probe, 1'b1, rpc[li], (k != tr - 1), "R7");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule